// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A single-port synchronous SRAM that accepts a new read or write command on every enabled clock edge and never needs an idle cycle when the bus turns from reads to writes. Address and control are registered on the rising edge. Write data is taken a fixed number of enabled edges after its command, and that distance matches the read latency. A write issued right after a read therefore uses the data bus one cycle after the read data has left it.

A static mode input selects one of two timings. In pipelined mode, read data passes through an output register, and write data is taken two enabled edges after the command. In flow-through mode, read data comes straight from the array after the address edge, and write data is taken on the next enabled edge. Storage is organised as 9-bit byte lanes, each with its own active-low write enable. Three chip selects, a clock enable that stalls every internal register, an asynchronous output enable and a sleep input complete the interface. The bidirectional data bus is split into `din`, `dout` and a drive-enable flag `dout_en`. When `dout_en` is low, the bus counts as high-Z.

Top module: `zt_sram`

## Requirements
- R1: In pipelined mode (`flow_mode`=0), a read command registered at enabled edge k drives the word on `dout`, with `dout_en` high, from enabled edge k+1 onwards.
- R2: In flow-through mode (`flow_mode`=1), a read command registered at enabled edge k drives the word from edge k onwards, until the next enabled edge.
- R3: In pipelined mode, a write command registered at enabled edge k stores `din` as sampled at enabled edge k+2.
- R4: In flow-through mode, a write command registered at enabled edge k stores `din` as sampled at enabled edge k+1.
- R5: A command is accepted only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. With any select inactive the edge makes no access and leads to no drive.
- R6: A write command with every `bw_n` bit high changes no word and leaves `dout_en` low.
- R7: Lane i is bits [9i+8:9i] of `din` and `dout`. A write updates only the lanes whose `bw_n[i]` is 0.
- R8: An edge with `cke_n`=1 changes no state. A read being shown keeps driving the same data, and a pending write is held until enabled edges resume.
- R9: `oe_n`=1 forces `dout_en` low at once, with no clock edge needed. A read issued with `oe_n` high changes no memory.
- R10: While `sleep`=1, `dout_en` is low and every edge is treated as a held edge: commands are ignored.
- R11: A read of an address whose write is still pending returns, lane by lane, the pending write data for the enabled lanes and the stored data for the others.
- R12: `dout` is all zeros whenever `dout_en` is low.
- R13: While `rst_n` is low, no command is pending and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flow_mode | input | 1 | 1 = flow-through timing, 0 = pipelined timing; static after reset |
| cke_n | input | 1 | Clock enable, active low; high holds all state |
| sleep | input | 1 | Sleep, active high; holds state and turns the drive off |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | 0 = write command, 1 = read command |
| bw_n | input | NUM_LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| din | input | NUM_LANES*LANE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | NUM_LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | Drive flag; low means high-Z |

## Verification
The bench builds the block with ADDR_W=4 (16 words), four lanes of 9 bits. With so few words, random commands hit addresses that still have a write in flight very often, so the per-lane bypass and write-after-write orderings are exercised without special steering. The same instance runs through both timings: the mode is changed under reset, so every latency rule is checked for pipelined and for flow-through operation.

// File: rtl/zt_pkg.sv
`timescale 1ns/1ps
package zt_pkg;
  // Kind of command held in a pipeline stage
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;
endpackage

// File: rtl/zt_cmd_stage.sv
`timescale 1ns/1ps
// Address/control register: decodes select, read, write and abort at each
// enabled edge.
module zt_cmd_stage
  import zt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 cs1_n,
  input  logic                 cs2,
  input  logic                 cs3_n,
  input  logic                 we_n,
  input  logic [NUM_LANES-1:0] bw_n,
  input  logic [ADDR_W-1:0]    addr,
  output cmd_e                 op_q,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [NUM_LANES-1:0] ben_q
);
  logic                 selected;
  logic                 any_lane;
  cmd_e                 op_d;
  logic [ADDR_W-1:0]    addr_d;
  logic [NUM_LANES-1:0] ben_d;

  assign selected = ~cs1_n & cs2 & ~cs3_n;
  assign any_lane = |(~bw_n);

  always_comb begin
    op_d   = op_q;
    addr_d = addr_q;
    ben_d  = ben_q;
    if (adv) begin
      addr_d = addr;
      ben_d  = ~bw_n;
      if (!selected) begin
        op_d = CMD_NONE;
      end else if (we_n) begin
        op_d = CMD_READ;
      end else if (any_lane) begin
        op_d = CMD_WRITE;
      end else begin
        op_d = CMD_NONE;   // write abort
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= CMD_NONE;
      addr_q <= '0;
      ben_q  <= '0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
      ben_q  <= ben_d;
    end
  end
endmodule

// File: rtl/zt_wpipe.sv
`timescale 1ns/1ps
// Late-write shift pipeline. The commit tap is stage 0 in flow-through mode
// and stage 1 in pipelined mode.
module zt_wpipe
  import zt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic                 flow_mode,
  input  cmd_e                 s0_op,
  input  logic [ADDR_W-1:0]    s0_addr,
  input  logic [NUM_LANES-1:0] s0_ben,
  output logic [NUM_LANES-1:0] commit_lanes,
  output logic [ADDR_W-1:0]    commit_addr
);
  cmd_e                 s1_op_q, s1_op_d;
  logic [ADDR_W-1:0]    s1_addr_q, s1_addr_d;
  logic [NUM_LANES-1:0] s1_ben_q, s1_ben_d;

  always_comb begin
    s1_op_d   = s1_op_q;
    s1_addr_d = s1_addr_q;
    s1_ben_d  = s1_ben_q;
    if (adv) begin
      s1_op_d   = (s0_op == CMD_WRITE) ? CMD_WRITE : CMD_NONE;
      s1_addr_d = s0_addr;
      s1_ben_d  = s0_ben;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q   <= CMD_NONE;
      s1_addr_q <= '0;
      s1_ben_q  <= '0;
    end else begin
      s1_op_q   <= s1_op_d;
      s1_addr_q <= s1_addr_d;
      s1_ben_q  <= s1_ben_d;
    end
  end

  always_comb begin
    if (flow_mode) begin
      commit_lanes = (s0_op == CMD_WRITE) ? s0_ben : '0;
      commit_addr  = s0_addr;
    end else begin
      commit_lanes = (s1_op_q == CMD_WRITE) ? s1_ben_q : '0;
      commit_addr  = s1_addr_q;
    end
  end
endmodule

// File: rtl/zt_array.sv
`timescale 1ns/1ps
// Byte-lane storage: one array per lane, one write port and one read port.
module zt_array #(
  parameter int ADDR_W    = 8,
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 9
) (
  input  logic                        clk,
  input  logic                        adv,
  input  logic [NUM_LANES-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]           waddr,
  input  logic [NUM_LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]           raddr,
  output logic [NUM_LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic              lane_we;

    assign lane_we = adv & wr_lanes[g];

    always_ff @(posedge clk) begin
      if (lane_we) begin
        mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/zt_rdpath.sv
`timescale 1ns/1ps
// Read path: pipelined output register with per-lane bypass of the write that
// commits on the same edge, mode mux, and drive gating.
module zt_rdpath
  import zt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  input  logic                        flow_mode,
  input  cmd_e                        s0_op,
  input  logic [ADDR_W-1:0]           s0_addr,
  input  logic [NUM_LANES*LANE_W-1:0] arr_rdata,
  input  logic [NUM_LANES-1:0]        commit_lanes,
  input  logic [ADDR_W-1:0]           commit_addr,
  input  logic [NUM_LANES*LANE_W-1:0] din,
  input  logic                        oe_n,
  input  logic                        sleep,
  output logic [NUM_LANES*LANE_W-1:0] dout,
  output logic                        dout_en
);
  localparam int DATA_W = NUM_LANES * LANE_W;

  logic              addr_hit;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] q_data_q, q_data_d;
  logic              q_vld_q, q_vld_d;
  logic [DATA_W-1:0] out_data;
  logic              out_vld;

  assign addr_hit = (commit_addr == s0_addr);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_byp
    assign merged[g*LANE_W +: LANE_W] = (addr_hit && commit_lanes[g])
                                        ? din[g*LANE_W +: LANE_W]
                                        : arr_rdata[g*LANE_W +: LANE_W];
  end

  always_comb begin
    q_data_d = q_data_q;
    q_vld_d  = q_vld_q;
    if (adv) begin
      q_data_d = merged;
      q_vld_d  = (s0_op == CMD_READ);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data_q <= '0;
      q_vld_q  <= 1'b0;
    end else begin
      q_data_q <= q_data_d;
      q_vld_q  <= q_vld_d;
    end
  end

  always_comb begin
    if (flow_mode) begin
      out_vld  = (s0_op == CMD_READ);
      out_data = arr_rdata;
    end else begin
      out_vld  = q_vld_q;
      out_data = q_data_q;
    end
  end

  assign dout_en = out_vld & ~oe_n & ~sleep;
  assign dout    = dout_en ? out_data : '0;
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flow_mode,
  input  logic                        cke_n,
  input  logic                        sleep,
  input  logic                        cs1_n,
  input  logic                        cs2,
  input  logic                        cs3_n,
  input  logic                        we_n,
  input  logic [NUM_LANES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_LANES*LANE_W-1:0] din,
  input  logic                        oe_n,
  output logic [NUM_LANES*LANE_W-1:0] dout,
  output logic                        dout_en
);
  localparam int DATA_W = NUM_LANES * LANE_W;

  logic                 adv;
  cmd_e                 s0_op;
  logic [ADDR_W-1:0]    s0_addr;
  logic [NUM_LANES-1:0] s0_ben;
  logic [NUM_LANES-1:0] commit_lanes;
  logic [ADDR_W-1:0]    commit_addr;
  logic [DATA_W-1:0]    arr_rdata;

  // Sleep and clock enable both freeze every register
  assign adv = ~cke_n & ~sleep;

  zt_cmd_stage #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .cs1_n  (cs1_n),
    .cs2    (cs2),
    .cs3_n  (cs3_n),
    .we_n   (we_n),
    .bw_n   (bw_n),
    .addr   (addr),
    .op_q   (s0_op),
    .addr_q (s0_addr),
    .ben_q  (s0_ben)
  );

  zt_wpipe #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES)) u_wpipe (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv          (adv),
    .flow_mode    (flow_mode),
    .s0_op        (s0_op),
    .s0_addr      (s0_addr),
    .s0_ben       (s0_ben),
    .commit_lanes (commit_lanes),
    .commit_addr  (commit_addr)
  );

  zt_array #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .adv      (adv),
    .wr_lanes (commit_lanes),
    .waddr    (commit_addr),
    .wdata    (din),
    .raddr    (s0_addr),
    .rdata    (arr_rdata)
  );

  zt_rdpath #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv          (adv),
    .flow_mode    (flow_mode),
    .s0_op        (s0_op),
    .s0_addr      (s0_addr),
    .arr_rdata    (arr_rdata),
    .commit_lanes (commit_lanes),
    .commit_addr  (commit_addr),
    .din          (din),
    .oe_n         (oe_n),
    .sleep        (sleep),
    .dout         (dout),
    .dout_en      (dout_en)
  );
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 9
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        flow_mode,
  input logic                        cke_n,
  input logic                        sleep,
  input logic                        cs1_n,
  input logic                        cs2,
  input logic                        cs3_n,
  input logic                        we_n,
  input logic [NUM_LANES-1:0]        bw_n,
  input logic                        oe_n,
  input logic [NUM_LANES*LANE_W-1:0] dout,
  input logic                        dout_en
);
  logic sel;
  logic go;
  assign sel = ~cs1_n & cs2 & ~cs3_n;
  assign go  = ~cke_n & ~sleep;

  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);

  p_sleep_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_n && !sleep && !oe_n) |=>
      ((!oe_n && !sleep) |-> ($stable(dout_en) && $stable(dout))));

  p_flow_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && go && sel && we_n) |=> ((!oe_n && !sleep) |-> dout_en));

  p_pipe_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && go && sel && we_n) ##1 go |=>
      ((!oe_n && !sleep) |-> dout_en));

  p_flow_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && go && !sel) |=> !dout_en);

  p_flow_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && go && sel && !we_n && (&bw_n)) |=> !dout_en);
endmodule

bind zt_sram zt_sram_chk #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flow_mode (flow_mode),
  .cke_n     (cke_n),
  .sleep     (sleep),
  .cs1_n     (cs1_n),
  .cs2       (cs2),
  .cs3_n     (cs3_n),
  .we_n      (we_n),
  .bw_n      (bw_n),
  .oe_n      (oe_n),
  .dout      (dout),
  .dout_en   (dout_en)
);

// File: tb/sim_zt_sram.sv
`timescale 1ns/1ps
module sim_zt_sram;
  localparam int AW    = 4;
  localparam int NB    = 4;
  localparam int LW    = 9;
  localparam int DW    = NB * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          flow_mode;
  logic          cke_n, sleep, cs1_n, cs2, cs3_n, we_n, oe_n;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en;

  zt_sram #(.ADDR_W(AW), .NUM_LANES(NB), .LANE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .cke_n(cke_n),
    .sleep(sleep), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .we_n(we_n),
    .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n), .dout(dout),
    .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string tag    = "";

  // Reference model, built from the requirements
  logic [DW-1:0] m_mem [DEPTH];
  logic          pw_v [2];
  logic [AW-1:0] pw_a [2];
  logic [NB-1:0] pw_b [2];
  logic          pr_v;
  logic [AW-1:0] pr_a;
  logic          e_vld;
  logic [DW-1:0] e_data;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [NB-1:0] ben);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < NB; i++)
      if (ben[i]) r[i*LW +: LW] = new_w[i*LW +: LW];   // R7 lane i = [9i+8:9i]
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    logic [DW-1:0] w;
    w = {$urandom(), $urandom()};
    return w;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      pw_v[i] = 1'b0; pw_a[i] = '0; pw_b[i] = '0;
    end
    pr_v = 1'b0; pr_a = '0; e_vld = 1'b0; e_data = '0;
  endtask

  // Applied once per rising edge, using the inputs held across that edge
  task automatic model_edge();
    bit sel, isw, isr;
    if (cke_n || sleep) return;                       // R8, R10
    sel = !cs1_n && cs2 && !cs3_n;                    // R5
    isw = sel && !we_n && (bw_n != '1);               // R6
    isr = sel && we_n;
    if (pw_v[0]) m_mem[pw_a[0]] = lane_merge(m_mem[pw_a[0]], din, pw_b[0]);
    pw_v[0] = pw_v[1]; pw_a[0] = pw_a[1]; pw_b[0] = pw_b[1];
    pw_v[1] = 1'b0;
    if (isw) begin
      if (flow_mode) begin   // R4: data one edge later
        pw_v[0] = 1'b1; pw_a[0] = addr; pw_b[0] = ~bw_n;
      end else begin         // R3: data two edges later
        pw_v[1] = 1'b1; pw_a[1] = addr; pw_b[1] = ~bw_n;
      end
    end
    if (flow_mode) begin     // R2
      e_vld = isr;
      if (isr) e_data = m_mem[addr];
    end else begin           // R1, R11 via commit before lookup
      e_vld = pr_v;
      if (pr_v) e_data = m_mem[pr_a];
      pr_v = isr; pr_a = addr;
    end
  endtask

  task automatic check_out();
    logic  exp_en;
    string t;
    exp_en = e_vld && !oe_n && !sleep;
    if (tag != "") t = tag;
    else if (oe_n) t = "R9";
    else if (sleep) t = "R10";
    else if (exp_en) t = flow_mode ? "R2" : "R1";
    else t = "R12";
    checks++;
    if (dout_en !== exp_en || (exp_en && dout !== e_data) ||
        (!exp_en && dout !== '0)) begin
      errors++;
      $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
               t, dout_en, dout, exp_en, exp_en ? e_data : '0);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_out();
  endtask

  task automatic cyc(input bit ck, input bit sl, input bit c1, input bit c2,
                     input bit c3, input bit w, input logic [NB-1:0] b,
                     input logic [AW-1:0] a, input bit o);
    cke_n = ck; sleep = sl; cs1_n = c1; cs2 = c2; cs3_n = c3; we_n = w;
    bw_n = b; addr = a; din = rnd_word(); oe_n = o;
    step();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] b);
    cyc(0, 0, 0, 1, 0, 0, b, a, 0);
  endtask
  task automatic rd(input logic [AW-1:0] a);
    cyc(0, 0, 0, 1, 0, 1, '1, a, 0);
  endtask
  task automatic idle();
    cyc(0, 0, 1, 1, 0, 1, '1, '0, 0);
  endtask
  task automatic hold();
    cyc(1, 0, $urandom_range(0, 1), 1, 0, $urandom_range(0, 1), '0,
        AW'($urandom_range(0, DEPTH-1)), 0);
  endtask

  task automatic do_reset(input bit fm);
    rst_n = 1'b0; flow_mode = fm;
    cke_n = 0; sleep = 0; cs1_n = 1; cs2 = 0; cs3_n = 1; we_n = 1;
    bw_n = '1; addr = '0; din = '0; oe_n = 0;
    model_clear();
    @(negedge clk); @(negedge clk);
    tag = "R13"; check_out();   // R13: no drive during reset
    rst_n = 1'b1;
    @(negedge clk);
    check_out();
    tag = "";
  endtask

  task automatic run_mode(input bit fm);
    do_reset(fm);
    // preload every word
    tag = "R7";
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), '0);
    idle(); idle();
    // R3 / R4: late write timing with partial lanes (R7)
    tag = fm ? "R4" : "R3";
    wr(3, 4'b1010); idle(); idle(); rd(3); idle(); idle();
    wr(4, 4'b0110); rd(5); rd(4); idle(); idle();
    // R6: write abort
    tag = "R6";
    wr(5, 4'b1111); idle(); idle(); rd(5); idle(); idle();
    // R11: read right behind a pending write, per-lane merge
    tag = "R11";
    wr(7, 4'b0011); rd(7); idle(); idle();
    wr(8, 4'b0000); wr(8, 4'b1100); rd(8); rd(8); idle(); idle();
    // R8: held read keeps driving, held write waits
    tag = "R8";
    rd(9); hold(); hold(); idle(); hold(); idle();
    wr(10, 4'b0000); hold(); hold(); idle(); hold(); idle(); rd(10); idle(); idle();
    // R9: dummy read and asynchronous gating
    tag = "R9";
    cyc(0, 0, 0, 1, 0, 1, '1, 11, 1); idle();
    rd(11);
    if (!fm) idle();
    oe_n = 1'b1; #1 check_out();
    oe_n = 1'b0; #1 check_out();
    idle(); idle();
    // R10: sleep ignores commands and hides the bus
    tag = "R10";
    rd(12);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, 0, 0, '0, 12, 0);
    idle(); idle(); rd(12); idle(); idle();
    // R5: each select alone deselects
    tag = "R5";
    cyc(0, 0, 1, 1, 0, 0, '0, 13, 0);
    cyc(0, 0, 0, 0, 0, 0, '0, 13, 0);
    cyc(0, 0, 0, 1, 1, 0, '0, 13, 0);
    cyc(0, 0, 1, 1, 0, 1, '1, 13, 0);
    idle(); idle(); rd(13); idle(); idle();
    // constrained random traffic
    tag = "";
    for (int n = 0; n < 3000; n++) begin
      cyc($urandom_range(0, 9) == 0, $urandom_range(0, 19) == 0,
          $urandom_range(0, 14) == 0, $urandom_range(0, 14) != 0,
          $urandom_range(0, 14) == 0, $urandom_range(0, 1),
          ($urandom_range(0, 4) == 0) ? '1 : NB'($urandom()),
          AW'($urandom_range(0, DEPTH-1)), $urandom_range(0, 9) == 0);
    end
    idle(); idle();
  endtask

  initial begin
    void'($urandom(32'h2b5e_0d17));
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1: watchdog expired, run_done=0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule